// File: doc/BRIEF.md
# Banked Multiport Predicate Register File

This block stores the one-bit guard predicates of a dual-issue predicated processor. The predicates are held in a number of banks, 16 by default, each 8 bits wide. A bank-select register chooses the active bank. Each issue slot has a read port that returns its guard bit from the active bank. An instruction is treated as valid only when that bit reads 1.

Two compare instructions can retire in the same cycle. Each one writes a true bit and a complement bit, so the file has four single-bit write ports. These ports always target the active bank. A separate byte-wide port loads a whole bank chosen by number. A bank-change operation loads a new value into the bank-select register.

A compare result is produced late in the pipeline, so each read port takes a forwarded value that overrides the stored bit. Reads also see the writes made in the same cycle. Read outputs are registered and appear one cycle after the index is presented.

Top module: `pred_bank_file`

## Requirements
- R1: After a synchronous reset, cur_bank is 0, every predicate bit of every bank is 1, and both rd_pred outputs read 1.
- R2: rd_pred[r] in cycle n+1 equals bit rd_idx[r] of the active bank as it stands after all writes of cycle n, so a write in cycle n is visible to a read presented in the same cycle n.
- R3: When rd_fwd_en[r] is 1 in cycle n, rd_pred[r] in cycle n+1 equals rd_fwd_val[r], whatever the stored bit is.
- R4: A bit write port p with bw_en[p]=1 sets bit bw_idx[p] of the bank that cur_bank shows in that cycle to bw_val[p]. Other bits and banks are unchanged.
- R5: When several bit write ports target the same bit in one cycle, the port with the highest number wins. Ports 0 and 1 belong to slot 0 and ports 2 and 3 to slot 1, so slot 1 beats slot 0, and the second port of a slot beats its first.
- R6: A byte write with byte_we=1 loads bank byte_bank with byte_data, and bit i of byte_data becomes predicate i. This works for any bank, active or not.
- R7: When a byte write targets the active bank in the same cycle as bit writes, the bit writes are applied on top of the byte value.
- R8: With bank_we=1 in cycle n, cur_bank equals bank_new from cycle n+1 on. Reads and bit writes in cycle n still use the old bank, and those from cycle n+1 on use the new bank. With bank_we=0, cur_bank holds its value.
- R9: The two read ports are independent, and each can return a different bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_we | input | 1 | Bank-change strobe |
| bank_new | input | BANK_W | New bank-select value |
| cur_bank | output | BANK_W | Registered active bank |
| byte_we | input | 1 | Whole-bank write strobe |
| byte_bank | input | BANK_W | Bank loaded by the byte write |
| byte_data | input | BANK_BITS | Byte write data, bit i goes to predicate i |
| bw_en | input | NUM_BW | Bit write enables, one per port |
| bw_idx | input | NUM_BW x IDX_W | Bit index per bit write port |
| bw_val | input | NUM_BW | Bit value per bit write port |
| rd_idx | input | NUM_RD x IDX_W | Guard index per read port |
| rd_fwd_en | input | NUM_RD | Forward override enable per read port |
| rd_fwd_val | input | NUM_RD | Forwarded predicate value per read port |
| rd_pred | output | NUM_RD | Registered guard predicate per read port |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. This covers a read value with its same-cycle writes and forward, a bit or byte write seen by a read in the same cycle, and a new cur_bank value. The bench drives each cycle's inputs just after a falling edge. It advances a reference array of banks by the rules above, then compares rd_pred and cur_bank at the next falling edge, half a period after the capturing rising edge. A bank change is checked twice. It must not affect the reads and writes of its own cycle, and it must affect those of the following cycle. Both cases fall out of the same one-cycle sampling.

// File: rtl/pbf_pkg.sv
package pbf_pkg;
  localparam int PBF_BANKS_DEF = 16;
  localparam int PBF_BITS_DEF  = 8;
  localparam int PBF_RD_DEF    = 2;
  localparam int PBF_BW_DEF    = 4;
endpackage

// File: rtl/pbf_row_merge.sv
module pbf_row_merge #(
  parameter int BITS   = 8,
  parameter int NUM_BW = 4,
  parameter int IDX_W  = $clog2(BITS)
) (
  input  logic [BITS-1:0]                row_q,
  input  logic                           byte_hit,
  input  logic [BITS-1:0]                byte_data,
  input  logic                           bit_hit,
  input  logic [NUM_BW-1:0]              bw_en,
  input  logic [NUM_BW-1:0][IDX_W-1:0]   bw_idx,
  input  logic [NUM_BW-1:0]              bw_val,
  output logic [BITS-1:0]                row_d
);
  // byte load first, then bit ports in ascending order: highest port wins
  always_comb begin
    row_d = byte_hit ? byte_data : row_q;
    if (bit_hit) begin
      for (int p = 0; p < NUM_BW; p++) begin
        if (bw_en[p]) row_d[bw_idx[p]] = bw_val[p];
      end
    end
  end
endmodule

// File: rtl/pbf_read_port.sv
module pbf_read_port #(
  parameter int BITS  = 8,
  parameter int IDX_W = $clog2(BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BITS-1:0]  row,
  input  logic [IDX_W-1:0] idx,
  input  logic             fwd_en,
  input  logic             fwd_val,
  output logic             pred
);
  always_ff @(posedge clk) begin
    if (rst) pred <= 1'b1;
    else     pred <= fwd_en ? fwd_val : row[idx];
  end
endmodule

// File: rtl/pred_bank_file.sv
module pred_bank_file
  import pbf_pkg::*;
#(
  parameter int NUM_BANKS = PBF_BANKS_DEF,
  parameter int BANK_BITS = PBF_BITS_DEF,
  parameter int NUM_RD    = PBF_RD_DEF,
  parameter int NUM_BW    = PBF_BW_DEF,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int IDX_W    = $clog2(BANK_BITS)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bank_we,
  input  logic [BANK_W-1:0]             bank_new,
  output logic [BANK_W-1:0]             cur_bank,
  input  logic                          byte_we,
  input  logic [BANK_W-1:0]             byte_bank,
  input  logic [BANK_BITS-1:0]          byte_data,
  input  logic [NUM_BW-1:0]             bw_en,
  input  logic [NUM_BW-1:0][IDX_W-1:0]  bw_idx,
  input  logic [NUM_BW-1:0]             bw_val,
  input  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx,
  input  logic [NUM_RD-1:0]             rd_fwd_en,
  input  logic [NUM_RD-1:0]             rd_fwd_val,
  output logic [NUM_RD-1:0]             rd_pred
);
  logic [BANK_BITS-1:0] store_q [NUM_BANKS];
  logic [BANK_BITS-1:0] row_d   [NUM_BANKS];
  logic [BANK_BITS-1:0] sel_row;
  logic [BANK_W-1:0]    bank_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    pbf_row_merge #(.BITS(BANK_BITS), .NUM_BW(NUM_BW), .IDX_W(IDX_W)) u_merge (
      .row_q     (store_q[b]),
      .byte_hit  (byte_we && (byte_bank == BANK_W'(b))),
      .byte_data (byte_data),
      .bit_hit   (bank_q == BANK_W'(b)),
      .bw_en     (bw_en),
      .bw_idx    (bw_idx),
      .bw_val    (bw_val),
      .row_d     (row_d[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NUM_BANKS; b++) store_q[b] <= '1;
      bank_q <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) store_q[b] <= row_d[b];
      if (bank_we) bank_q <= bank_new;
    end
  end

  // reads see this cycle's writes in the bank active before any bank change
  assign sel_row  = row_d[bank_q];
  assign cur_bank = bank_q;

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    pbf_read_port #(.BITS(BANK_BITS), .IDX_W(IDX_W)) u_rd (
      .clk     (clk),
      .rst     (rst),
      .row     (sel_row),
      .idx     (rd_idx[r]),
      .fwd_en  (rd_fwd_en[r]),
      .fwd_val (rd_fwd_val[r]),
      .pred    (rd_pred[r])
    );
  end
endmodule

// File: rtl/pbf_checker.sv
module pbf_checker #(
  parameter int NUM_BANKS = 16,
  parameter int BANK_BITS = 8,
  parameter int NUM_RD    = 2,
  parameter int NUM_BW    = 4,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int IDX_W    = $clog2(BANK_BITS)
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          bank_we,
  input logic [BANK_W-1:0]             bank_new,
  input logic [BANK_W-1:0]             cur_bank,
  input logic                          byte_we,
  input logic [BANK_W-1:0]             byte_bank,
  input logic [BANK_BITS-1:0]          byte_data,
  input logic [NUM_BW-1:0]             bw_en,
  input logic [NUM_BW-1:0][IDX_W-1:0]  bw_idx,
  input logic [NUM_BW-1:0]             bw_val,
  input logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx,
  input logic [NUM_RD-1:0]             rd_fwd_en,
  input logic [NUM_RD-1:0]             rd_fwd_val,
  input logic [NUM_RD-1:0]             rd_pred
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (cur_bank == '0) && (rd_pred == '1));

  assert_forward_wins_R3: assert property (@(posedge clk) disable iff (rst)
    rd_fwd_en[0] |=> rd_pred[0] == $past(rd_fwd_val[0]));

  assert_top_port_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (bw_en[0] && bw_en[NUM_BW-1] && (bw_idx[0] == bw_idx[NUM_BW-1]) &&
     (rd_idx[0] == bw_idx[0]) && !rd_fwd_en[0])
    |=> rd_pred[0] == $past(bw_val[NUM_BW-1]));

  assert_byte_load_R6: assert property (@(posedge clk) disable iff (rst)
    (byte_we && (byte_bank == cur_bank) && (bw_en == '0) && !rd_fwd_en[0])
    |=> rd_pred[0] == $past(byte_data[rd_idx[0]]));

  assert_bank_change_R8: assert property (@(posedge clk) disable iff (rst)
    bank_we |=> cur_bank == $past(bank_new));

  assert_bank_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !bank_we |=> $stable(cur_bank));
endmodule

bind pred_bank_file pbf_checker #(
  .NUM_BANKS(NUM_BANKS), .BANK_BITS(BANK_BITS), .NUM_RD(NUM_RD), .NUM_BW(NUM_BW)
) u_pbf_checker (.*);

// File: tb/tb_pred_bank_file.sv
module tb_pred_bank_file;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 16;
  localparam int NBITS = 8;
  localparam int NR = 2;
  localparam int NW = 4;
  localparam int BW_ = $clog2(NB);
  localparam int IW = $clog2(NBITS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bank_we = 1'b0;
  logic [BW_-1:0] bank_new = '0;
  logic [BW_-1:0] cur_bank;
  logic byte_we = 1'b0;
  logic [BW_-1:0] byte_bank = '0;
  logic [NBITS-1:0] byte_data = '0;
  logic [NW-1:0] bw_en = '0;
  logic [NW-1:0][IW-1:0] bw_idx = '0;
  logic [NW-1:0] bw_val = '0;
  logic [NR-1:0][IW-1:0] rd_idx = '0;
  logic [NR-1:0] rd_fwd_en = '0;
  logic [NR-1:0] rd_fwd_val = '0;
  logic [NR-1:0] rd_pred;

  int n_chk = 0;
  int n_bad = 0;
  logic [NBITS-1:0] mdl [NB];
  logic [BW_-1:0] mbank;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  pred_bank_file dut (
    .clk(clk), .rst(rst), .bank_we(bank_we), .bank_new(bank_new), .cur_bank(cur_bank),
    .byte_we(byte_we), .byte_bank(byte_bank), .byte_data(byte_data),
    .bw_en(bw_en), .bw_idx(bw_idx), .bw_val(bw_val),
    .rd_idx(rd_idx), .rd_fwd_en(rd_fwd_en), .rd_fwd_val(rd_fwd_val), .rd_pred(rd_pred)
  );

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_bank(input string tag, input logic [BW_-1:0] act, input logic [BW_-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: cur_bank actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // one cycle: model the rules, wait for the capturing edge, compare half a period later
  task automatic tick(input string tag);
    logic [NBITS-1:0] nxt [NB];
    logic [NR-1:0] exp_rd;
    for (int b = 0; b < NB; b++) nxt[b] = mdl[b];
    if (byte_we) nxt[byte_bank] = byte_data;
    for (int p = 0; p < NW; p++) if (bw_en[p]) nxt[mbank][bw_idx[p]] = bw_val[p];
    for (int r = 0; r < NR; r++)
      exp_rd[r] = rd_fwd_en[r] ? rd_fwd_val[r] : nxt[mbank][rd_idx[r]];
    if (bank_we) mbank = bank_new;
    for (int b = 0; b < NB; b++) mdl[b] = nxt[b];
    @(negedge clk);
    for (int r = 0; r < NR; r++) check_bit(tag, rd_pred[r], exp_rd[r]);
    check_bank(tag, cur_bank, mbank);
    bank_we = 1'b0; byte_we = 1'b0; bw_en = '0; rd_fwd_en = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) mdl[b] = '1;
    mbank = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_bit("R1", rd_pred[0], 1'b1);
    check_bit("R1", rd_pred[1], 1'b1);
    check_bank("R1", cur_bank, '0);
    for (int i = 0; i < NBITS; i++) begin
      rd_idx[0] = IW'(i); rd_idx[1] = IW'(NBITS-1-i);
      tick("R1");
    end

    // bank sweep: change bank, load it, read every bit on both ports
    for (int b = 0; b < NB; b++) begin
      bank_we = 1'b1; bank_new = BW_'(b);
      tick("R8");
      byte_we = 1'b1; byte_bank = BW_'(b); byte_data = NBITS'(b * 37 ^ 8'h5A);
      rd_idx[0] = IW'(b % NBITS);
      tick("R6");
      for (int i = 0; i < NBITS; i++) begin
        rd_idx[0] = IW'(i); rd_idx[1] = IW'((i + 3) % NBITS);
        tick("R9");
      end
    end

    // load a bank that is not active, then visit it
    byte_we = 1'b1; byte_bank = 4'd9; byte_data = 8'hC3;
    tick("R6");
    bank_we = 1'b1; bank_new = 4'd9; rd_idx[0] = 3'd1;
    tick("R8");
    for (int i = 0; i < NBITS; i++) begin
      rd_idx[0] = IW'(i); rd_idx[1] = IW'(i);
      tick("R6");
    end

    // same-cycle read of a written bit
    bw_en = 4'b0001; bw_idx[0] = 3'd5; bw_val = 4'b0000; rd_idx[0] = 3'd5; rd_idx[1] = 3'd5;
    tick("R2");
    bw_en = 4'b0100; bw_idx[2] = 3'd5; bw_val = 4'b0100; rd_idx[0] = 3'd5;
    tick("R2");

    // single bit writes on each port
    for (int p = 0; p < NW; p++) begin
      for (int i = 0; i < NBITS; i++) begin
        bw_en = '0; bw_en[p] = 1'b1; bw_idx[p] = IW'(i); bw_val[p] = (i + p) % 2 == 1;
        rd_idx[0] = IW'(i); rd_idx[1] = IW'((i + 1) % NBITS);
        tick("R4");
      end
    end

    // bit writes on top of a byte write to the active bank
    byte_we = 1'b1; byte_bank = 4'd9; byte_data = 8'h00;
    bw_en = 4'b1000; bw_idx[3] = 3'd3; bw_val = 4'b1000;
    rd_idx[0] = 3'd3; rd_idx[1] = 3'd4;
    tick("R7");
    byte_we = 1'b1; byte_bank = 4'd9; byte_data = 8'hFF;
    bw_en = 4'b0011; bw_idx[0] = 3'd6; bw_idx[1] = 3'd0; bw_val = 4'b0000;
    rd_idx[0] = 3'd6; rd_idx[1] = 3'd0;
    tick("R7");

    // forward override against both stored values
    for (int v = 0; v < 4; v++) begin
      rd_fwd_en = 2'b11; rd_fwd_val = 2'(v); rd_idx[0] = 3'd6; rd_idx[1] = 3'd3;
      tick("R3");
    end

    // bank change together with a bit write: old bank is written
    bank_we = 1'b1; bank_new = 4'd2; bw_en = 4'b0001; bw_idx[0] = 3'd7; bw_val = 4'b0000;
    rd_idx[0] = 3'd7;
    tick("R8");
    bank_we = 1'b1; bank_new = 4'd9; rd_idx[0] = 3'd7;
    tick("R8");
    tick("R8");

    // random collisions among all writers
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] a;
      logic [31:0] c;
      a = rnd(); c = rnd();
      bw_en = a[3:0];
      for (int p = 0; p < NW; p++) bw_idx[p] = (a[8] ? IW'(a[6:4]) : IW'(c[3*p +: 3]));
      bw_val = a[12:9];
      byte_we = (a[15:13] == 3'd0);
      byte_bank = c[15:12];
      byte_data = c[23:16];
      bank_we = (a[19:16] == 4'd0);
      bank_new = a[23:20];
      rd_idx[0] = a[8] ? IW'(a[6:4]) : IW'(a[26:24]);
      rd_idx[1] = IW'(a[29:27]);
      rd_fwd_en = (c[27:25] == 3'd0) ? 2'(c[29:28]) : 2'b00;
      rd_fwd_val = 2'(c[31:30]);
      tick("R5");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule